// File: doc/BRIEF.md
# Paddle Game Score Keeper

This block tracks the running score of a single-player paddle-and-ball game. The game logic sends it two event levels. One rises when the ball meets the paddle, and the other rises when the ball reaches the bottom edge of the playfield. Each paddle contact earns a point and each miss costs a point. A miss that arrives with no points left ends the game.

The score and a game-over flag are registered outputs. Play logic can use the flag to freeze the ball, and display logic can show the score. A synchronous restart input, normally driven by a debounced button, clears both outputs to start a new game. The asynchronous active-low reset puts the block in the same clean state at power-up.

Top module: `paddle_score_keeper`

## Requirements
- R1: A rising edge on `hit_i` raises `score_o` by one.
- R2: A rising edge on `miss_i` while `score_o` is nonzero lowers `score_o` by one and leaves `game_over_o` low.
- R3: A rising edge on `miss_i` while `score_o` is zero sets `game_over_o` and keeps `score_o` at zero. While `game_over_o` is high, `score_o` is zero.
- R4: `restart_i` high at a clock edge clears `score_o` and `game_over_o` at that edge. It takes priority over any event seen in the same cycle.
- R5: An event input that stays high for several clocks counts once. It must go low and rise again before it counts a second time.
- R6: `score_o` is 8 bits wide by default and saturates at 255: a hit at 255 leaves it at 255.
- R7: While `game_over_o` is high, hit and miss edges change neither output until a restart.
- R8: When hit and miss edges occur in the same cycle, only the miss is applied.
- R9: Both outputs are registered. They change on the clock edge that first samples the event high, and not before that edge.
- R10: `rst_ni` low clears `score_o`, `game_over_o` and the edge history asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous new-game clear |
| hit_i | input | 1 | Ball met paddle (level, edge-counted) |
| miss_i | input | 1 | Ball reached bottom (level, edge-counted) |
| score_o | output | SCORE_W | Current score |
| game_over_o | output | 1 | Game has ended |

## Verification
The bench aims at the boundaries of the score value. At zero, a design that wraps would jump to 255 on a miss instead of ending the game. At 255, one that overflows would fall back to zero on a further hit. Held event levels test the edge detection: a level-counting design would add a point on every clock. Simultaneous hit and miss, events arriving during game-over, and a restart coinciding with an event catch wrong priority ordering. A long pseudo-random run compared against an arithmetic model of the rules checks every transition cycle by cycle.

// File: rtl/score_pkg.sv
package score_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HIT  = 2'd1,
    EV_MISS = 2'd2
  } score_ev_e;
endpackage

// File: rtl/score_edge_detect.sv
module score_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end
endmodule

// File: rtl/score_event_arb.sv
module score_event_arb
  import score_pkg::*;
(
  input  logic      hit_rise_i,
  input  logic      miss_rise_i,
  input  logic      game_over_i,
  output score_ev_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (!game_over_i) begin
      if (miss_rise_i)     ev_o = EV_MISS;  // miss wins a tie
      else if (hit_rise_i) ev_o = EV_HIT;
    end
  end
endmodule

// File: rtl/score_counter.sv
module score_counter
  import score_pkg::*;
#(
  parameter int unsigned SCORE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  score_ev_e          ev_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               game_over_o
);
  localparam logic [SCORE_W-1:0] SCORE_MAX = '1;

  logic [SCORE_W-1:0] score_q;
  logic               over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q <= '0;
      over_q  <= 1'b0;
    end else if (restart_i) begin
      score_q <= '0;
      over_q  <= 1'b0;
    end else begin
      unique case (ev_i)
        EV_MISS: begin
          if (score_q == '0) over_q  <= 1'b1;
          else               score_q <= score_q - 1'b1;
        end
        EV_HIT: begin
          if (score_q != SCORE_MAX) score_q <= score_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign score_o     = score_q;
  assign game_over_o = over_q;

  AST_OVER_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_q |-> score_q == '0);  // R3
  AST_NO_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_q == SCORE_MAX && !restart_i && ev_i != EV_MISS) |=> score_q == SCORE_MAX);  // R6
endmodule

// File: rtl/paddle_score_keeper.sv
module paddle_score_keeper
  import score_pkg::*;
#(
  parameter int unsigned SCORE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               hit_i,
  input  logic               miss_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               game_over_o
);
  localparam int unsigned NUM_EV = 2;
  localparam int unsigned HIT_B  = 0;
  localparam int unsigned MISS_B = 1;
  localparam logic [SCORE_W-1:0] SCORE_MAX = '1;

  logic [NUM_EV-1:0] ev_lvl, ev_rise;
  score_ev_e         ev;

  assign ev_lvl[HIT_B]  = hit_i;
  assign ev_lvl[MISS_B] = miss_i;

  score_edge_detect #(.N(NUM_EV)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (ev_lvl),
    .rise_o (ev_rise)
  );

  score_event_arb u_arb (
    .hit_rise_i  (ev_rise[HIT_B]),
    .miss_rise_i (ev_rise[MISS_B]),
    .game_over_i (game_over_o),
    .ev_o        (ev)
  );

  score_counter #(.SCORE_W(SCORE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart_i),
    .ev_i        (ev),
    .score_o     (score_o),
    .game_over_o (game_over_o)
  );

  AST_HIT_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !game_over_o && ev_rise[HIT_B] && !ev_rise[MISS_B] && score_o != SCORE_MAX)
    |=> score_o == $past(score_o) + 1'b1);  // R1
  AST_MISS_SUBS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !game_over_o && ev_rise[MISS_B] && score_o != '0)
    |=> (score_o == $past(score_o) - 1'b1) && !game_over_o);  // R2
  AST_MISS_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !game_over_o && ev_rise[MISS_B] && score_o == '0)
    |=> game_over_o && score_o == '0);  // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> score_o == '0 && !game_over_o);  // R4
  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && ev_rise == '0) |=> $stable(score_o) && $stable(game_over_o));  // R5
  AST_FROZEN_WHEN_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && game_over_o) |=> game_over_o && $stable(score_o));  // R7
endmodule

// File: tb/paddle_score_keeper_tb.sv
module paddle_score_keeper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0, hit = 1'b0, miss = 1'b0;
  logic [7:0] score;
  logic       over;

  int n_chk = 0, n_fail = 0;
  int m_score = 0;
  bit m_over = 0, m_ph = 0, m_pm = 0;
  bit done = 0;

  always #5 clk = ~clk;

  paddle_score_keeper #(.SCORE_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart),
    .hit_i(hit), .miss_i(miss), .score_o(score), .game_over_o(over)
  );

  task automatic check(input string req, input int exp_s, input bit exp_o);
    n_chk++;
    if (score !== exp_s[7:0] || over !== exp_o) begin
      n_fail++;
      $display("FAIL %s: score=%0d over=%0b expected score=%0d over=%0b",
               req, score, over, exp_s, exp_o);
    end
  endtask

  // model of the rules, applied once per clock edge
  task automatic model_edge();
    bit hr, mr;
    hr = hit & ~m_ph;
    mr = miss & ~m_pm;
    m_ph = hit;
    m_pm = miss;
    if (restart) begin
      m_score = 0; m_over = 0;
    end else if (!m_over) begin
      if (mr) begin
        if (m_score == 0) m_over = 1; else m_score--;
      end else if (hr) begin
        if (m_score != 255) m_score++;
      end
    end
  endtask

  // called at a negedge: drive, cross one posedge, land on next negedge
  task automatic step(input bit h, input bit m, input bit r);
    hit = h; miss = m; restart = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic do_reset();
    hit = 0; miss = 0; restart = 0;
    rst_n = 0;
    #3;
    m_score = 0; m_over = 0; m_ph = 0; m_pm = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    @(negedge clk);
    check("R10 reset state", 0, 0);
    rst_n = 1;
    @(negedge clk);

    // R9: nothing before the edge, update right after it
    hit = 1;
    #2;
    check("R9 no change before edge", 0, 0);
    @(posedge clk); model_edge(); @(negedge clk);
    check("R1 first hit", 1, 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R5 held hit counts once", 1, 0);
    step(0, 0, 0); step(1, 0, 0);
    check("R1 second hit", 2, 0);
    step(0, 1, 0);
    check("R2 miss subtracts", 1, 0);
    step(0, 1, 0); step(0, 1, 0);
    check("R5 held miss counts once", 1, 0);
    step(0, 0, 0); step(1, 1, 0);
    check("R8 tie applies miss only", 0, 0);
    step(0, 0, 0); step(0, 1, 0);
    check("R3 miss at zero ends game", 0, 1);
    step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 1, 0);
    check("R7 events ignored after game over", 0, 1);
    step(0, 0, 1);
    check("R4 restart clears", 0, 0);
    step(1, 0, 1);
    check("R4 restart beats hit", 0, 0);
    step(0, 0, 0);
    for (int i = 0; i < 260; i++) begin
      step(1, 0, 0);
      step(0, 0, 0);
    end
    check("R6 saturates at 255", 255, 0);
    step(0, 1, 0);
    check("R2 miss from 255", 254, 0);
    do_reset();
    check("R10 async reset mid-run", 0, 0);

    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      bit h, m, r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      h = lfsr[0] | lfsr[3];
      m = lfsr[1] & lfsr[2] & lfsr[5];
      r = (lfsr[11:7] == 5'd0);
      step(h, m, r);
      check("R1/R2/R3/R7/R8 sweep", m_score, m_over);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule